// File: doc/BRIEF.md
# Two-Key Register Write Gate

This block sits between a bus write port and a peripheral register file. It decides, for each write, whether the register file may take it. Writes that land in a protected address window are held back until software opens the gate. Software opens it by writing one fixed 32-bit key to a first kick register and then a second fixed 32-bit key to a second kick register. Writing zero, or any other wrong value, to either kick register shuts the gate again. Reads do not pass through this block, so they are never affected.

The gate drives a combinational per-write enable, `wr_allow`, toward the register file. It also drives a lock indication and a sticky violation flag. These two outputs are meant to be mapped into a readable status word by the surrounding logic. A write that the gate blocks is dropped without any response on the bus. Only the violation flag records it.

Addresses are decoded per word. The low `ADDR_LSB` address bits pick a byte lane and are ignored when the gate matches the kick registers and the protected window.

Top module: `wp_write_gate`

## Requirements
- R1: After reset `locked` is 1 and `violation` is 0.
- R2: Writing 0x83E70B13 to the first kick register (word offset 0x6C) and then 0x95A4F1E0 to the second kick register (word offset 0x70) opens the gate. `locked` reads 0 from the cycle after the second write.
- R3: Writing the second key while the first key has not been accepted leaves the gate locked.
- R4: Any value other than its key, written to either kick register, shuts the gate and restarts the sequence. A later second-key write alone then does not open it.
- R5: Writing zero to the kick registers returns an open gate to the locked state.
- R6: While the gate is locked, a write to the protected window (word offsets 0x00 to 0x9C, kick registers excluded) gives `wr_allow`=0. It sets `violation` in the next cycle, and `violation` stays 1 until reset, even after the gate opens.
- R7: While the gate is open, every write to the protected window gives `wr_allow`=1 and leaves `violation` unchanged.
- R8: Writes to either kick register give `wr_allow`=1 whatever the lock state.
- R9: Writes outside the protected window (offsets 0xA0 and up) give `wr_allow`=1 and never set `violation`.
- R10: `wr_allow` is 0 in every cycle where `wr_en` is 0.
- R11: Address matching ignores the low two byte-lane bits. For example, a key written to offset 0x6F counts as a write to the first kick register.
- R12: Writing the first key again while the gate is open locks it until the second key follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Bus write strobe |
| wr_addr | input | ADDR_W (8) | Byte address of the write |
| wr_data | input | DATA_W (32) | Write data |
| wr_allow | output | 1 | Write enable toward the register file for this cycle |
| locked | output | 1 | 1 while protected writes are blocked |
| violation | output | 1 | Sticky flag: a protected write was dropped |

## Verification
The bench sweeps every byte address with the gate locked and again with it open. A decoder that put the window edge at the wrong word, or that fed the byte-lane bits into the compare, would let a protected write through or block a free one. It drives the key sequence out of order, with a wrong value between the two keys, and with the first key repeated while the gate is open. A state machine that remembered a half-entered sequence, or treated the second key as enough on its own, would open when it should not. It also checks that the violation flag survives a later unlock and is not raised by writes outside the window; a flag tied to the lock state would clear or fire wrongly.

// File: rtl/wp_pkg.sv
package wp_pkg;
   typedef enum logic [1:0] {
      GATE_SHUT = 2'd0,
      GATE_HALF = 2'd1,
      GATE_OPEN = 2'd2
   } gate_state_e;
endpackage

// File: rtl/wp_addr_decode.sv
module wp_addr_decode #(
   parameter int unsigned             ADDR_W     = 8,
   parameter int unsigned             ADDR_LSB   = 2,
   parameter logic [ADDR_W-1:0]       KICK0_ADDR = 8'h6C,
   parameter logic [ADDR_W-1:0]       KICK1_ADDR = 8'h70,
   parameter logic [ADDR_W-1:0]       PROT_LO    = 8'h00,
   parameter logic [ADDR_W-1:0]       PROT_HI    = 8'h9C
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              hit_k0,
   output logic              hit_k1,
   output logic              in_win
);
   logic [ADDR_W-1:0] idx, k0_idx, k1_idx, lo_idx, hi_idx;

   generate
      if (ADDR_LSB == 0) begin : g_byte
         assign idx    = addr;
         assign k0_idx = KICK0_ADDR;
         assign k1_idx = KICK1_ADDR;
         assign lo_idx = PROT_LO;
         assign hi_idx = PROT_HI;
      end else begin : g_word
         assign idx    = addr       >> ADDR_LSB;
         assign k0_idx = KICK0_ADDR >> ADDR_LSB;
         assign k1_idx = KICK1_ADDR >> ADDR_LSB;
         assign lo_idx = PROT_LO    >> ADDR_LSB;
         assign hi_idx = PROT_HI    >> ADDR_LSB;
      end
   endgenerate

   assign hit_k0 = (idx == k0_idx);
   assign hit_k1 = (idx == k1_idx);
   // offset from the window base compared with the window span
   assign in_win = ((idx - lo_idx) <= (hi_idx - lo_idx));
endmodule

// File: rtl/wp_key_seq.sv
module wp_key_seq
   import wp_pkg::*;
#(
   parameter int unsigned        DATA_W = 32,
   parameter logic [DATA_W-1:0]  KEY0   = 32'h83E7_0B13,
   parameter logic [DATA_W-1:0]  KEY1   = 32'h95A4_F1E0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              hit_k0,
   input  logic              hit_k1,
   input  logic [DATA_W-1:0] wr_data,
   output logic              is_open
);
   gate_state_e st_q, st_d;

   always_comb begin
      st_d = st_q;
      if (wr_en && hit_k0) begin
         st_d = (wr_data == KEY0) ? GATE_HALF : GATE_SHUT;
      end else if (wr_en && hit_k1) begin
         if ((wr_data == KEY1) && (st_q != GATE_SHUT))
            st_d = GATE_OPEN;
         else
            st_d = GATE_SHUT;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) st_q <= GATE_SHUT;
      else        st_q <= st_d;
   end

   assign is_open = (st_q == GATE_OPEN);
endmodule

// File: rtl/wp_fault_flag.sv
module wp_fault_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_req,
   output logic flag
);
   always_ff @(posedge clk) begin
      if (!rst_n)       flag <= 1'b0;
      else if (set_req) flag <= 1'b1;
   end
endmodule

// File: rtl/wp_write_gate.sv
module wp_write_gate #(
   parameter int unsigned        ADDR_W     = 8,
   parameter int unsigned        DATA_W     = 32,
   parameter int unsigned        ADDR_LSB   = 2,
   parameter logic [ADDR_W-1:0]  KICK0_ADDR = 8'h6C,
   parameter logic [ADDR_W-1:0]  KICK1_ADDR = 8'h70,
   parameter logic [ADDR_W-1:0]  PROT_LO    = 8'h00,
   parameter logic [ADDR_W-1:0]  PROT_HI    = 8'h9C,
   parameter logic [DATA_W-1:0]  KEY0       = 32'h83E7_0B13,
   parameter logic [DATA_W-1:0]  KEY1       = 32'h95A4_F1E0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic              wr_allow,
   output logic              locked,
   output logic              violation
);
   localparam logic [ADDR_W-1:0] K0_W = KICK0_ADDR >> ADDR_LSB;
   localparam logic [ADDR_W-1:0] K1_W = KICK1_ADDR >> ADDR_LSB;

   generate
      if (ADDR_LSB >= ADDR_W) begin : g_chk_lsb
         $error("ADDR_LSB must be below ADDR_W");
      end
      if (K0_W == K1_W) begin : g_chk_kick
         $error("kick registers must decode to different words");
      end
      if (PROT_LO > PROT_HI) begin : g_chk_win
         $error("protected window is empty");
      end
      if ((KEY0 == '0) || (KEY1 == '0)) begin : g_chk_key
         $error("a zero key would make relocking impossible");
      end
   endgenerate

   logic hit_k0, hit_k1, in_win, is_open, kick_hit, prot_hit;

   wp_addr_decode #(
      .ADDR_W(ADDR_W), .ADDR_LSB(ADDR_LSB),
      .KICK0_ADDR(KICK0_ADDR), .KICK1_ADDR(KICK1_ADDR),
      .PROT_LO(PROT_LO), .PROT_HI(PROT_HI)
   ) u_dec (
      .addr(wr_addr), .hit_k0(hit_k0), .hit_k1(hit_k1), .in_win(in_win)
   );

   wp_key_seq #(
      .DATA_W(DATA_W), .KEY0(KEY0), .KEY1(KEY1)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
      .hit_k0(hit_k0), .hit_k1(hit_k1), .wr_data(wr_data),
      .is_open(is_open)
   );

   assign kick_hit = hit_k0 | hit_k1;
   assign prot_hit = in_win & ~kick_hit;

   wp_fault_flag u_flag (
      .clk(clk), .rst_n(rst_n),
      .set_req(wr_en & prot_hit & ~is_open),
      .flag(violation)
   );

   assign wr_allow = wr_en & (~prot_hit | is_open);
   assign locked   = ~is_open;
endmodule

// File: rtl/wp_write_gate_chk.sv
module wp_write_gate_chk #(
   parameter int unsigned        ADDR_W     = 8,
   parameter int unsigned        DATA_W     = 32,
   parameter int unsigned        ADDR_LSB   = 2,
   parameter logic [ADDR_W-1:0]  KICK0_ADDR = 8'h6C,
   parameter logic [ADDR_W-1:0]  KICK1_ADDR = 8'h70,
   parameter logic [ADDR_W-1:0]  PROT_LO    = 8'h00,
   parameter logic [ADDR_W-1:0]  PROT_HI    = 8'h9C,
   parameter logic [DATA_W-1:0]  KEY0       = 32'h83E7_0B13,
   parameter logic [DATA_W-1:0]  KEY1       = 32'h95A4_F1E0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [DATA_W-1:0] wr_data,
   input logic              wr_allow,
   input logic              locked,
   input logic              violation
);
   logic k0, k1, kick, prot;
   assign k0   = (wr_addr >> ADDR_LSB) == (KICK0_ADDR >> ADDR_LSB);
   assign k1   = (wr_addr >> ADDR_LSB) == (KICK1_ADDR >> ADDR_LSB);
   assign kick = k0 | k1;
   assign prot = ((wr_addr >> ADDR_LSB) >= (PROT_LO >> ADDR_LSB)) &&
                 ((wr_addr >> ADDR_LSB) <= (PROT_HI >> ADDR_LSB)) && !kick;

   p_unlock_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(locked) |-> $past(wr_en && k1 && (wr_data == KEY1)));

   p_zero_relock_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && kick && (wr_data == '0)) |=> locked);

   p_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && prot && locked) |-> !wr_allow);

   p_flag_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && prot && locked) |=> violation);

   p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      violation |=> violation);

   p_kick_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && kick) |-> wr_allow);

   p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |-> !wr_allow);
endmodule

bind wp_write_gate wp_write_gate_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ADDR_LSB(ADDR_LSB),
   .KICK0_ADDR(KICK0_ADDR), .KICK1_ADDR(KICK1_ADDR),
   .PROT_LO(PROT_LO), .PROT_HI(PROT_HI), .KEY0(KEY0), .KEY1(KEY1)
) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
   .wr_data(wr_data), .wr_allow(wr_allow), .locked(locked),
   .violation(violation)
);

// File: tb/tb_wp_write_gate.sv
module tb_wp_write_gate;
   localparam logic [31:0] K0 = 32'h83E7_0B13;
   localparam logic [31:0] K1 = 32'h95A4_F1E0;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic       wr_allow, locked, violation;

   int unsigned n_chk = 0;
   int unsigned n_bad = 0;
   logic        got;

   always #4 clk = ~clk;

   wp_write_gate dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .wr_allow(wr_allow), .locked(locked),
      .violation(violation)
   );

   function automatic bit is_kick(input int a);
      return ((a >> 2) == 'h1B) || ((a >> 2) == 'h1C);
   endfunction

   function automatic bit is_prot(input int a);
      return ((a >> 2) <= 'h27) && !is_kick(a);
   endfunction

   task automatic check(input string req, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %b expected %b", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      wr_en = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   // one write; allow sampled mid-cycle, state visible at the next negedge
   task automatic wr(input logic [7:0] a, input logic [31:0] d, output logic allow);
      @(negedge clk);
      wr_en = 1'b1;
      wr_addr = a;
      wr_data = d;
      #1 allow = wr_allow;
      @(posedge clk);
      #1 wr_en = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      #(8 * 150000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      do_reset();
      @(negedge clk);
      check("R1 locked after reset", locked, 1'b1);
      check("R1 violation after reset", violation, 1'b0);

      // R10: idle strobe with a protected address
      wr_addr = 8'h10;
      #1 check("R10 no strobe", wr_allow, 1'b0);

      // R9: free addresses while locked
      for (int a = 'hA0; a < 256; a++) begin
         wr(a[7:0], 32'h1234_5678, got);
         check("R9 free address allowed", got, 1'b1);
      end
      check("R9 no violation from free writes", violation, 1'b0);

      // R3 and R8: second key first
      wr(8'h70, K1, got);
      check("R8 kick write allowed while locked", got, 1'b1);
      check("R3 second key alone", locked, 1'b1);

      // R2: proper sequence
      wr(8'h6C, K0, got);
      check("R8 kick0 allowed", got, 1'b1);
      check("R2 half sequence still locked", locked, 1'b1);
      wr(8'h70, K1, got);
      check("R2 open after both keys", locked, 1'b0);

      // R7: every non-kick address open
      for (int a = 0; a < 256; a++) begin
         if (!is_kick(a)) begin
            wr(a[7:0], 32'hA5A5_0000 | a, got);
            check("R7 open write allowed", got, 1'b1);
         end
      end
      check("R7 still open", locked, 1'b0);
      check("R7 violation unchanged", violation, 1'b0);

      // R5: zero relocks
      wr(8'h6C, 32'h0, got);
      check("R5 zero to kick0 locks", locked, 1'b1);
      wr(8'h70, 32'h0, got);
      check("R5 zero to kick1 keeps locked", locked, 1'b1);

      // R4: wrong value on kick0 between keys
      wr(8'h6C, K0, got);
      wr(8'h6C, 32'hDEAD_BEEF, got);
      wr(8'h70, K1, got);
      check("R4 wrong kick0 value restarts", locked, 1'b1);
      // R4: wrong value on kick1 after first key
      wr(8'h6C, K0, got);
      wr(8'h70, K1 ^ 32'h1, got);
      check("R4 wrong kick1 value locks", locked, 1'b1);
      wr(8'h70, K1, got);
      check("R4 retry of second key alone", locked, 1'b1);

      // R11: byte-lane addresses of the kick words
      wr(8'h6F, K0, got);
      wr(8'h71, K1, got);
      check("R11 lane offsets unlock", locked, 1'b0);

      // R12: first key again while open
      wr(8'h6C, K0, got);
      check("R12 repeat first key locks", locked, 1'b1);
      wr(8'h04, 32'h1, got);
      check("R12 protected blocked in half state", got, 1'b0);
      wr(8'h70, K1, got);
      check("R12 second key reopens", locked, 1'b0);

      // R6: locked sweep from a clean reset
      do_reset();
      wr(8'h00, 32'h1234_5678, got);
      check("R6 first protected write dropped", got, 1'b0);
      check("R6 violation set", violation, 1'b1);
      for (int a = 0; a < 256; a++) begin
         wr(a[7:0], 32'h1234_5678, got);
         check("R6 locked sweep allow", got, !is_prot(a));
      end
      check("R6 still locked after sweep", locked, 1'b1);
      wr(8'h6C, K0, got);
      wr(8'h70, K1, got);
      check("R6 unlock after violation", locked, 1'b0);
      check("R6 violation sticky across unlock", violation, 1'b1);

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule